// File: doc/BRIEF.md
# Set/Clear/Status Control Register Bank

This block holds a small bank of 32-bit control registers that sit behind a simple synchronous peripheral bus. Software reaches each register through three word addresses. Writing to the first address ORs the written word into the register. Writing to the second address removes every bit that is one in the written word. Reading the third address returns the current contents. Software can therefore change single control bits with one store and no read-modify-write sequence. The register contents drive the `ctrl` output toward the rest of the peripheral.

The bank decodes a 14-bit byte offset inside the peripheral's 16 KB window. Offset zero, the lowest address of the window, holds the first register's set location. Logic inside the peripheral may also clear bits through `hw_clr`. When that input and a bus set act on the same bit in the same cycle, the clear wins.

The read path is a two-state machine. `RD_IDLE` drives zero on `rdata`. `RD_DONE` drives the word captured by the preceding read. A selected read in either state moves the machine to `RD_DONE` (transition *read-accept*). Any cycle without a selected read moves it to `RD_IDLE` (transition *read-release*).

Top module: `scs_reg_bank`

## Requirements
- R1: Register i (0 to NUM_REGS-1) answers at byte offset 12*i for set, 12*i+4 for clear and 12*i+8 for status. Bits [1:0] of the offset are ignored, so the window base at offset 0 is register 0's set address.
- R2: A write to a set address makes every bit that is one in `wdata` a one in that register.
- R3: A write to a clear address makes every bit that is one in `wdata` a zero in that register.
- R4: A write to a set or clear address leaves unchanged every register bit where `wdata` is zero, and it leaves all other registers unchanged.
- R5: A write to a status address or to an unmapped offset changes no register.
- R6: A read of a set address, a clear address or an unmapped offset returns zero.
- R7: A one on `hw_clr` clears that bit at the next edge, and it takes priority over a bus set to the same bit in the same cycle.
- R8: `rdata` carries the read value in the cycle after a read with `sel` high and `we` low. In every other cycle `rdata` is zero.
- R9: A synchronous active-high `rst` sets every register bit to zero and returns the read machine to `RD_IDLE`.
- R10: `ctrl` shows register i on bits [32*i+31:32*i] and follows a write at the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Bus select for this peripheral window |
| we | input | 1 | Write enable (1 = write, 0 = read) |
| addr | input | 14 | Byte offset within the 16 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| hw_clr | input | NUM_REGS*32 (128) | Per-bit clear requests from peripheral logic |
| ctrl | output | NUM_REGS*32 (128) | Current register contents |

## Verification
A write or an `hw_clr` pulse that is accepted at a rising edge shows on `ctrl` right after that edge. The bench applies stimulus at a falling edge and samples `ctrl` at the next falling edge, which is exactly one edge later. A read value takes one register stage, so the bench samples `rdata` at the falling edge that follows the accepting edge. The latency test also samples one edge earlier, to see zero before the read, and one edge later, to see zero again after `RD_DONE` is released. Every check samples half a period away from the active edge, so no check depends on the order of processes at the edge.

// File: rtl/scs_pkg.sv
package scs_pkg;
    localparam int WORD_BYTES    = 4;
    localparam int SLOTS_PER_REG = 3;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_DONE = 1'b1
    } rd_state_t;

    // word slot order inside one register's triple
    typedef enum logic [1:0] {
        SLOT_SET = 2'd0,
        SLOT_CLR = 2'd1,
        SLOT_STS = 2'd2
    } slot_t;

    function automatic int slot_word(input int reg_idx, input slot_t s);
        return reg_idx * SLOTS_PER_REG + int'(s);
    endfunction
endpackage

// File: rtl/scs_decode.sv
module scs_decode
    import scs_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] set_wr,
    output logic [NUM_REGS-1:0] clr_wr,
    output logic [NUM_REGS-1:0] sts_rd
);
    localparam int SHIFT = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] word_idx;
    assign word_idx = addr >> SHIFT;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] W_SET = ADDR_W'(slot_word(i, SLOT_SET));
        localparam logic [ADDR_W-1:0] W_CLR = ADDR_W'(slot_word(i, SLOT_CLR));
        localparam logic [ADDR_W-1:0] W_STS = ADDR_W'(slot_word(i, SLOT_STS));
        assign set_wr[i] = sel && we  && (word_idx == W_SET);
        assign clr_wr[i] = sel && we  && (word_idx == W_CLR);
        assign sts_rd[i] = sel && !we && (word_idx == W_STS);
    end

    // R1: one address reaches at most one slot of one register
    a_r1_one_slot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_wr, clr_wr, sts_rd}));
    // R5: nothing is decoded without select
    a_r5_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !sel |-> ({set_wr, clr_wr, sts_rd} == '0));
endmodule

// File: rtl/scs_bitreg.sv
module scs_bitreg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_clr,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] q_next;

    always_comb begin
        set_mask = set_en ? wdata : '0;
        clr_mask = (clr_en ? wdata : '0) | hw_clr;
        // clear is applied last so it wins
        q_next   = (q | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

    // R2: set bits become one unless hardware clears them
    a_r2_set_ones: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((q & ($past(wdata) & ~$past(hw_clr))) == ($past(wdata) & ~$past(hw_clr))));
    // R3: clear bits become zero
    a_r3_clear_ones: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((q & $past(wdata)) == '0));
    // R4: untouched bits hold their value
    a_r4_zero_holds: assert property (@(posedge clk) disable iff (rst || $past(rst))
        1'b1 |=> (((q ^ $past(q)) &
                   ~(($past(set_en) || $past(clr_en)) ? $past(wdata) : '0) &
                   ~$past(hw_clr)) == '0));
    // R7: hardware clear beats any set
    a_r7_hw_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (hw_clr != '0) |=> ((q & $past(hw_clr)) == '0));
    // R9: reset empties the register
    a_r9_reset_zero: assert property (@(posedge clk)
        rst |=> (q == '0));
endmodule

// File: rtl/scs_rdpath.sv
module scs_rdpath
    import scs_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_req,
    input  logic [NUM_REGS-1:0]          sts_rd,
    input  logic [NUM_REGS*DATA_W-1:0]   regs,
    output logic [DATA_W-1:0]            rdata
);
    rd_state_t         state_q;
    rd_state_t         state_d;
    logic [DATA_W-1:0] mux_val;
    logic [DATA_W-1:0] cap_q;

    always_comb begin
        mux_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sts_rd[i]) mux_val = mux_val | regs[i*DATA_W +: DATA_W];
        end
    end

    // state transitions: read-accept / read-release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_req)  state_d = RD_DONE;
            RD_DONE: if (!rd_req) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RD_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)         cap_q <= '0;
        else if (rd_req) cap_q <= mux_val;
    end

    // output process
    always_comb begin
        unique case (state_q)
            RD_DONE: rdata = cap_q;
            default: rdata = '0;
        endcase
    end

    // R8: a read is answered in the next cycle
    a_r8_read_next: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> (state_q == RD_DONE));
    // R8: bus is quiet when no read was taken
    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> (rdata == '0));
    // R1: at most one status slot feeds the mux
    a_r1_single_status: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sts_rd));
endmodule

// File: rtl/scs_reg_bank.sv
module scs_reg_bank
    import scs_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sel,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic [NUM_REGS*DATA_W-1:0] hw_clr,
    output logic [NUM_REGS*DATA_W-1:0] ctrl
);
    localparam int BANK_W = NUM_REGS * DATA_W;

    logic [NUM_REGS-1:0] set_wr;
    logic [NUM_REGS-1:0] clr_wr;
    logic [NUM_REGS-1:0] sts_rd;
    logic [BANK_W-1:0]   bank_q;
    logic                rd_req;

    assign rd_req = sel && !we;

    scs_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .we     (we),
        .addr   (addr),
        .set_wr (set_wr),
        .clr_wr (clr_wr),
        .sts_rd (sts_rd)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        scs_bitreg #(.DATA_W(DATA_W)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .set_en (set_wr[i]),
            .clr_en (clr_wr[i]),
            .wdata  (wdata),
            .hw_clr (hw_clr[i*DATA_W +: DATA_W]),
            .q      (bank_q[i*DATA_W +: DATA_W])
        );
    end

    scs_rdpath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_req (rd_req),
        .sts_rd (sts_rd),
        .regs   (bank_q),
        .rdata  (rdata)
    );

    assign ctrl = bank_q;

    // R5: status and unmapped writes leave the bank alone
    a_r5_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        (set_wr == '0 && clr_wr == '0 && hw_clr == '0) |=> $stable(ctrl));
    // R6: reads that hit no status slot return zero
    a_r6_zero_read: assert property (@(posedge clk) disable iff (rst)
        (rd_req && sts_rd == '0) |=> (rdata == '0));
endmodule

// File: tb/scs_reg_bank_test.sv
`timescale 1ns/1ps
module scs_reg_bank_test;
    localparam int NR = 4;
    localparam int DW = 32;
    localparam int AW = 14;
    localparam int VEC_W = 1 + 4 + AW + DW + DW;
    localparam int NV = 22;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sel = 1'b0;
    logic            we  = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic [NR*DW-1:0] hw_clr = '0;
    logic [NR*DW-1:0] ctrl;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    scs_reg_bank #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .hw_clr(hw_clr), .ctrl(ctrl)
    );

    // {is_read, req, addr, data, expected}
    localparam logic [VEC_W-1:0] VECS [NV] = '{
        {1'b0, 4'd2,  14'h0000, 32'hA5A5_0000, 32'h0},           // R2 set r0
        {1'b1, 4'd2,  14'h0008, 32'h0,         32'hA5A5_0000},
        {1'b0, 4'd3,  14'h0004, 32'h0500_0000, 32'h0},           // R3 clear r0
        {1'b1, 4'd3,  14'h0008, 32'h0,         32'hA0A5_0000},
        {1'b0, 4'd4,  14'h0004, 32'h0000_0000, 32'h0},           // R4 zero clear
        {1'b0, 4'd4,  14'h0000, 32'h0000_000F, 32'h0},           // R4 partial set
        {1'b1, 4'd4,  14'h0008, 32'h0,         32'hA0A5_000F},
        {1'b0, 4'd1,  14'h000C, 32'hFFFF_FFFF, 32'h0},           // R1 set r1
        {1'b1, 4'd1,  14'h0014, 32'h0,         32'hFFFF_FFFF},
        {1'b1, 4'd4,  14'h0008, 32'h0,         32'hA0A5_000F},   // R4 r0 untouched
        {1'b0, 4'd3,  14'h0010, 32'h0F0F_0F0F, 32'h0},           // R3 clear r1
        {1'b1, 4'd3,  14'h0014, 32'h0,         32'hF0F0_F0F0},
        {1'b0, 4'd5,  14'h0008, 32'hFFFF_FFFF, 32'h0},           // R5 status write
        {1'b1, 4'd5,  14'h0008, 32'h0,         32'hA0A5_000F},
        {1'b1, 4'd6,  14'h0000, 32'h0,         32'h0},           // R6 set addr read
        {1'b1, 4'd6,  14'h0010, 32'h0,         32'h0},           // R6 clear addr read
        {1'b1, 4'd6,  14'h3FFC, 32'h0,         32'h0},           // R6 unmapped
        {1'b0, 4'd1,  14'h0024, 32'h8000_0001, 32'h0},           // R1 set r3
        {1'b1, 4'd1,  14'h002C, 32'h0,         32'h8000_0001},
        {1'b1, 4'd1,  14'h002E, 32'h0,         32'h8000_0001},   // R1 low bits ignored
        {1'b0, 4'd5,  14'h0030, 32'hFFFF_FFFF, 32'h0},           // R5 unmapped write
        {1'b1, 4'd5,  14'h0020, 32'h0,         32'h0}
    };

    task automatic check(input string tag, input logic [NR*DW-1:0] act,
                         input logic [NR*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        sel = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset ctrl", ctrl, '0);
        check("R9 reset rdata", {96'h0, rdata}, '0);

        for (int k = 0; k < NV; k++) begin
            logic [VEC_W-1:0] v;
            v = VECS[k];
            if (v[VEC_W-1]) begin
                bus_read(v[2*DW +: AW], rd);
                check($sformatf("R%0d vector %0d", v[2*DW+AW +: 4], k),
                      {96'h0, rd}, {96'h0, v[DW-1:0]});
            end else begin
                bus_write(v[2*DW +: AW], v[DW +: DW]);
            end
        end

        // R10: ctrl mapping and timing
        @(negedge clk);
        check("R10 ctrl before write", ctrl[2*DW +: DW], 32'h0);
        sel = 1'b1; we = 1'b1; addr = 14'h0018; wdata = 32'h0000_00FF;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = '0;
        check("R10 ctrl after write", ctrl[2*DW +: DW], 32'h0000_00FF);
        check("R10 ctrl r0 slice", ctrl[0 +: DW], 32'hA0A5_000F);

        // R7: hardware clear beats a same-cycle bus set
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = 14'h0018; wdata = 32'h0000_0F01;
        hw_clr[2*DW +: DW] = 32'h0000_0101;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = '0; hw_clr = '0;
        check("R7 clear priority", ctrl[2*DW +: DW], 32'h0000_0EFE);
        hw_clr[DW +: DW] = 32'hF000_0000;
        @(negedge clk);
        hw_clr = '0;
        check("R7 hw clear alone", ctrl[DW +: DW], 32'h00F0_F0F0);

        // R8: read latency and release
        @(negedge clk);
        check("R8 idle before read", {96'h0, rdata}, '0);
        sel = 1'b1; we = 1'b0; addr = 14'h0020;
        @(negedge clk);
        sel = 1'b0;
        check("R8 data next cycle", {96'h0, rdata}, {96'h0, 32'h0000_0EFE});
        @(negedge clk);
        check("R8 released", {96'h0, rdata}, '0);

        // R9: mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset clears bank", ctrl, '0);
        bus_read(14'h0014, rd);
        check("R9 status after reset", {96'h0, rd}, '0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule